// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a virtual address into a physical address by fetching descriptors from a two-level translation table in memory. A requester presents a virtual address, a security tag and the table base. The walker then issues one or two descriptor reads on a simple read port. Every read carries the security tag of the request that started the walk. The walker handles one request at a time and keeps its ready output low until the result has been delivered.

The first-level descriptor can be a fault, a pointer to a second-level table, a 1MB block or a 16MB block. A second-level descriptor can be a fault, a 64KB page or a 4KB page. For a page, the walker picks one of four two-bit permission fields using virtual-address bits, and which bits it uses depends on the page size. The response gives the physical address, the chosen permission field, the domain, the memory-type bits, a size code, a sharing flag and an execute-never flag. In this compatible format every mapping is reported as executable and global.

Top module: `xw_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle after the single-cycle response.
- R2: The first read address is {ttb_base[31:14], VA[31:20], 2'b00}. For a table pointer, the second read address is {L1[31:10], VA[19:12], 2'b00}.
- R3: Every descriptor read, first or second level, drives `mem_ns` equal to the `req_ns` of the accepted request.
- R4: `mem_req` stays high, with `mem_addr` and `mem_ns` stable, until `mem_gnt` is seen. Each walk level is requested exactly once, and its data is taken on the cycle `mem_rvalid` is high.
- R5: A first-level descriptor with bits [1:0] equal to 00 or 11 ends the walk after one read with `rsp_fault` = 1.
- R6: L1 bits [1:0] = 10 with bit 18 = 0 gives a 1MB block. PA = {L1[31:20], VA[19:0]}, AP = L1[11:10], domain = L1[8:5], TEX = L1[14:12], C = L1[3], B = L1[2], size code 2.
- R7: L1 bits [1:0] = 10 with bit 18 = 1 gives a 16MB block. PA = {L1[31:24], VA[23:0]}, domain = 0, size code 3. AP, TEX, C and B come from the same positions as in R6.
- R8: L1 bits [1:0] = 01 starts a second read. Any resulting page reports domain L1[8:5]. A second-level descriptor with bits [1:0] = 00 gives `rsp_fault` = 1 after two reads.
- R9: L2 bits [1:0] = 01 gives a 64KB page. PA = {L2[31:16], VA[15:0]}, TEX = L2[14:12], C = L2[3], B = L2[2], size code 1. AP is field n = VA[15:14], taken from L2 bits [5+2n:4+2n].
- R10: L2 bit 1 = 1 gives a 4KB page. PA = {L2[31:12], VA[11:0]}, TEX = 0, C = L2[3], B = L2[2], size code 0. AP is field n = VA[11:10], taken from L2 bits [5+2n:4+2n].
- R11: `rsp_xn` is always 0. `rsp_shared` is 1 exactly when the result is not a fault, TEX = 000 and C = 0; all other, normal, memory reports 0.
- R12: `rsp_valid` is a one-cycle pulse. On a fault, PA, AP, domain, TEX, C, B, size and shared all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address to translate |
| req_ns | input | 1 | Security tag of the request (1 = non-secure) |
| ttb_base | input | 32 | Translation table base, bits [31:14] used |
| mem_req | output | 1 | Descriptor read request |
| mem_gnt | input | 1 | Read request accepted |
| mem_addr | output | 32 | Descriptor read address |
| mem_ns | output | 1 | Security tag of the read |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Result present (one cycle) |
| rsp_fault | output | 1 | Translation fault |
| rsp_pa | output | 32 | Physical address |
| rsp_ap | output | 2 | Selected access-permission field |
| rsp_domain | output | 4 | Domain number |
| rsp_tex | output | 3 | TEX bits |
| rsp_c | output | 1 | C bit |
| rsp_b | output | 1 | B bit |
| rsp_size | output | 2 | 0 = 4KB, 1 = 64KB, 2 = 1MB, 3 = 16MB |
| rsp_shared | output | 1 | Shareable (device) memory |
| rsp_xn | output | 1 | Execute-never, always 0 |

## Verification
The bench sweeps all eight descriptor-type paths: two first-level faults, the 1MB and 16MB blocks, and table pointers followed by each of the four second-level codes. It runs each path for every subpage index and both security tags. The virtual address carries the subpage index in VA[15:14] and its complement in VA[11:10]. A 64KB page and a 4KB page therefore expect different AP fields, so a swap of the selecting bits shows up in the result. The memory model answers only the exact first- and second-level addresses, and it counts the reads and any security-tag mismatch. Read latency and grant stalls vary across walks, which shows whether a request is repeated or dropped while the walker waits.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int DOM_W  = 4;
    localparam int TEX_W  = 3;
    localparam int AP_W   = 2;
    localparam int SUBPG  = 4;
    localparam int CB_W   = AW - 10;
    localparam int TB_W   = AW - 14;

    typedef enum logic [2:0] {
        S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        SZ_SMALL = 2'd0, SZ_LARGE = 2'd1, SZ_SECT = 2'd2, SZ_SUPER = 2'd3
    } map_sz_e;

    typedef struct packed {
        logic              fault;
        logic [AW-1:0]     pa;
        logic [AP_W-1:0]   ap;
        logic [DOM_W-1:0]  dom;
        logic [TEX_W-1:0]  tex;
        logic              c;
        logic              b;
        map_sz_e           sz;
        logic              shared;
    } xlat_res_t;

    typedef struct packed {
        walk_st_e          st;
        logic [AW-1:0]     va;
        logic              ns;
        logic [TB_W-1:0]   tbase;
        logic [CB_W-1:0]   cbase;
        logic [DOM_W-1:0]  cdom;
        xlat_res_t         res;
    } walk_reg_t;

    // Strongly-ordered and shared-device encodings are the only shareable ones here.
    function automatic logic shared_of(input logic [TEX_W-1:0] tex, input logic c);
        return (tex == '0) && !c;
    endfunction
endpackage

// File: rtl/xw_l1_dec.sv
module xw_l1_dec
    import xw_pkg::*;
(
    input  logic [DW-1:0]    desc,
    input  logic [AW-1:0]    va,
    output logic             is_table,
    output xlat_res_t        res,
    output logic [CB_W-1:0]  cbase,
    output logic [DOM_W-1:0] cdom
);
    always_comb begin
        res       = '0;
        res.fault = 1'b1;
        is_table  = 1'b0;
        cbase     = desc[AW-1:10];
        cdom      = desc[8:5];
        case (desc[1:0])
            2'b01: begin
                is_table  = 1'b1;
                res.fault = 1'b0;
            end
            2'b10: begin
                res.fault  = 1'b0;
                res.ap     = desc[11:10];
                res.tex    = desc[14:12];
                res.c      = desc[3];
                res.b      = desc[2];
                res.shared = shared_of(desc[14:12], desc[3]);
                if (desc[18]) begin
                    res.pa = {desc[31:24], va[23:0]};
                    res.sz = SZ_SUPER;
                end else begin
                    res.pa  = {desc[31:20], va[19:0]};
                    res.dom = desc[8:5];
                    res.sz  = SZ_SECT;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xw_l2_dec.sv
module xw_l2_dec
    import xw_pkg::*;
(
    input  logic [DW-1:0]    desc,
    input  logic [AW-1:0]    va,
    input  logic [DOM_W-1:0] dom_in,
    output xlat_res_t        res
);
    localparam int SEL_W = $clog2(SUBPG);

    logic [AP_W-1:0]  ap_fld [SUBPG];
    logic [SEL_W-1:0] sel;

    for (genvar i = 0; i < SUBPG; i++) begin : g_ap
        assign ap_fld[i] = desc[4 + AP_W*i +: AP_W];
    end

    assign sel = desc[1] ? va[11:10] : va[15:14];

    always_comb begin
        res       = '0;
        res.fault = 1'b1;
        if (desc[1:0] != 2'b00) begin
            res.fault = 1'b0;
            res.dom   = dom_in;
            res.ap    = ap_fld[sel];
            res.c     = desc[3];
            res.b     = desc[2];
            if (desc[1]) begin
                res.pa  = {desc[31:12], va[11:0]};
                res.sz  = SZ_SMALL;
                res.tex = '0;
            end else begin
                res.pa  = {desc[31:16], va[15:0]};
                res.sz  = SZ_LARGE;
                res.tex = desc[14:12];
            end
            res.shared = shared_of(res.tex, desc[3]);
        end
    end
endmodule

// File: rtl/xw_walker.sv
module xw_walker
    import xw_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [31:0]   req_va,
    input  logic          req_ns,
    input  logic [31:0]   ttb_base,
    output logic          mem_req,
    input  logic          mem_gnt,
    output logic [31:0]   mem_addr,
    output logic          mem_ns,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic [31:0]   rsp_pa,
    output logic [1:0]    rsp_ap,
    output logic [3:0]    rsp_domain,
    output logic [2:0]    rsp_tex,
    output logic          rsp_c,
    output logic          rsp_b,
    output logic [1:0]    rsp_size,
    output logic          rsp_shared,
    output logic          rsp_xn
);
    walk_reg_t q, d;

    logic             l1_table;
    xlat_res_t        l1_res, l2_res;
    logic [CB_W-1:0]  l1_cbase;
    logic [DOM_W-1:0] l1_cdom;
    logic [AW-1:0]    l1_addr, l2_addr;

    xw_l1_dec u_l1 (
        .desc(mem_rdata), .va(q.va), .is_table(l1_table),
        .res(l1_res), .cbase(l1_cbase), .cdom(l1_cdom)
    );

    xw_l2_dec u_l2 (
        .desc(mem_rdata), .va(q.va), .dom_in(q.cdom), .res(l2_res)
    );

    assign l1_addr = {q.tbase, q.va[31:20], 2'b00};
    assign l2_addr = {q.cbase, q.va[19:12], 2'b00};

    always_comb begin
        d        = q;
        mem_req  = 1'b0;
        mem_addr = (q.st == S_L2_REQ) ? l2_addr : l1_addr;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.va    = req_va;
                    d.ns    = req_ns;
                    d.tbase = ttb_base[AW-1:14];
                    d.st    = S_L1_REQ;
                end
            end
            S_L1_REQ: begin
                mem_req = 1'b1;
                if (mem_gnt) d.st = S_L1_WAIT;
            end
            S_L1_WAIT: begin
                if (mem_rvalid) begin
                    if (l1_table) begin
                        d.cbase = l1_cbase;
                        d.cdom  = l1_cdom;
                        d.st    = S_L2_REQ;
                    end else begin
                        d.res = l1_res;
                        d.st  = S_DONE;
                    end
                end
            end
            S_L2_REQ: begin
                mem_req = 1'b1;
                if (mem_gnt) d.st = S_L2_WAIT;
            end
            S_L2_WAIT: begin
                if (mem_rvalid) begin
                    d.res = l2_res;
                    d.st  = S_DONE;
                end
            end
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == S_IDLE);
    assign mem_ns     = q.ns;
    assign rsp_valid  = (q.st == S_DONE);
    assign rsp_fault  = q.res.fault;
    assign rsp_pa     = q.res.pa;
    assign rsp_ap     = q.res.ap;
    assign rsp_domain = q.res.dom;
    assign rsp_tex    = q.res.tex;
    assign rsp_c      = q.res.c;
    assign rsp_b      = q.res.b;
    assign rsp_size   = q.res.sz;
    assign rsp_shared = q.res.shared;
    assign rsp_xn     = 1'b0;
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_ns,
    input logic        mem_req,
    input logic        mem_gnt,
    input logic [31:0] mem_addr,
    input logic        mem_ns,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [31:0] rsp_pa,
    input logic        rsp_c,
    input logic        rsp_shared
);
    logic ns_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) ns_cap <= 1'b0;
        else if (req_valid && req_ready) ns_cap <= req_ns;
    end

    p_idle_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    p_read_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_ns == ns_cap));

    p_hold_until_gnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_ns)));

    p_shared_normal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_c) |-> !rsp_shared);

    p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_fault_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && !rsp_shared));
endmodule

bind xw_walker xw_walker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ns(req_ns), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
    .mem_ns(mem_ns), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_pa(rsp_pa), .rsp_c(rsp_c), .rsp_shared(rsp_shared)
);

// File: tb/sim_xw_walker.sv
`timescale 1ns/1ps
module sim_xw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_ns = 1'b0;
    logic [31:0] ttb_base = 32'h4000_C000;
    logic        mem_req;
    logic        mem_gnt = 1'b1;
    logic [31:0] mem_addr;
    logic        mem_ns;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, rsp_fault, rsp_c, rsp_b, rsp_shared, rsp_xn;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_ap, rsp_size;
    logic [3:0]  rsp_domain;
    logic [2:0]  rsp_tex;

    always #2.5 clk = ~clk;

    xw_walker u0 (.*);

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // memory model state
    logic [31:0] m_l1d = '0, m_l2d = '0, m_l1a = '0, m_l2a = '0;
    logic        m_ns = 1'b0;
    int          m_lat = 0;
    bit          m_slow = 0;
    int          n_reads = 0, n_bad_addr = 0, n_bad_ns = 0;
    bit          pend = 0;
    int          wait_c = 0;
    logic [31:0] pend_data = '0;

    always @(posedge clk) begin
        mem_gnt <= m_slow ? ~mem_gnt : 1'b1;
        mem_rvalid <= 1'b0;
        if (pend) begin
            if (wait_c == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= pend_data;
                pend       <= 0;
            end else wait_c <= wait_c - 1;
        end else if (rst_n && mem_req && mem_gnt) begin
            pend    <= 1;
            wait_c  <= m_lat;
            n_reads <= n_reads + 1;
            if (mem_ns != m_ns) n_bad_ns <= n_bad_ns + 1;
            if (mem_addr == m_l1a) pend_data <= m_l1d;
            else if (mem_addr == m_l2a) pend_data <= m_l2d;
            else begin
                pend_data  <= 32'h0;
                n_bad_addr <= n_bad_addr + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // kind: 0 fault00, 1 fault11, 2 section, 3 supersection, 4..7 table + L2 code (kind-4)
    task automatic walk(input int kind, input int sel, input int nsv);
        logic [31:0] h1, h2, va, l1d, l2d;
        logic        e_fault, e_c, e_b, e_sh;
        logic [31:0] e_pa;
        logic [1:0]  e_ap, e_sz;
        logic [3:0]  e_dom;
        logic [2:0]  e_tex;
        int          e_reads, r0, ba0, bn0, cyc, n;
        string       rq;
        h1  = 32'h9E37_79B9 * (kind * 8 + sel + nsv * 37 + 1);
        h2  = 32'h85EB_CA6B * (kind * 5 + sel * 3 + nsv + 7);
        va  = h2 ^ 32'h1234_5678;
        va[15:14] = sel[1:0];
        va[11:10] = 2'd3 - sel[1:0];
        l1d = h1;
        l2d = h2;
        l2d[11:4] = sel[0] ? 8'h1B : 8'hE4;
        case (kind)
            0: l1d[1:0] = 2'b00;
            1: l1d[1:0] = 2'b11;
            2: begin l1d[1:0] = 2'b10; l1d[18] = 1'b0; end
            3: begin l1d[1:0] = 2'b10; l1d[18] = 1'b1; end
            default: begin l1d[1:0] = 2'b01; l2d[1:0] = 2'(kind - 4); end
        endcase
        if (sel == 2) begin l1d[14:12] = 3'b000; l1d[3] = 1'b0; l2d[3] = 1'b0; end
        if (sel == 2 && kind == 5) l2d[14:12] = 3'b000;

        // expected result
        e_fault = 1'b0; e_pa = '0; e_ap = '0; e_dom = '0; e_tex = '0;
        e_c = 1'b0; e_b = 1'b0; e_sz = 2'd0; e_reads = 1;
        case (kind)
            0, 1: begin e_fault = 1'b1; rq = "R5"; end
            2: begin
                rq = "R6"; e_pa = {l1d[31:20], va[19:0]}; e_ap = l1d[11:10];
                e_dom = l1d[8:5]; e_tex = l1d[14:12]; e_c = l1d[3]; e_b = l1d[2]; e_sz = 2'd2;
            end
            3: begin
                rq = "R7"; e_pa = {l1d[31:24], va[23:0]}; e_ap = l1d[11:10];
                e_tex = l1d[14:12]; e_c = l1d[3]; e_b = l1d[2]; e_sz = 2'd3;
            end
            default: begin
                e_reads = 2;
                if (l2d[1:0] == 2'b00) begin e_fault = 1'b1; rq = "R8"; end
                else begin
                    e_dom = l1d[8:5]; e_c = l2d[3]; e_b = l2d[2];
                    if (l2d[1:0] == 2'b01) begin
                        rq = "R9"; n = int'(va[15:14]);
                        e_pa = {l2d[31:16], va[15:0]}; e_tex = l2d[14:12]; e_sz = 2'd1;
                    end else begin
                        rq = "R10"; n = int'(va[11:10]);
                        e_pa = {l2d[31:12], va[11:0]}; e_tex = 3'd0; e_sz = 2'd0;
                    end
                    e_ap = 2'((l2d >> (4 + 2 * n)) & 32'h3);
                end
            end
        endcase
        e_sh = !e_fault && (e_tex == 3'd0) && !e_c;

        // program memory model
        @(negedge clk);
        m_l1d = l1d; m_l2d = l2d; m_ns = nsv[0];
        m_l1a = {ttb_base[31:14], va[31:20], 2'b00};
        m_l2a = (kind >= 4) ? {l1d[31:10], va[19:12], 2'b00} : 32'hFFFF_FFFF;
        m_lat = (kind + sel) % 3;
        m_slow = (sel == 1) || (sel == 3 && nsv == 1);
        r0 = n_reads; ba0 = n_bad_addr; bn0 = n_bad_ns;
        chk(req_ready == 1'b1, "R1", "ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_va = va; req_ns = nsv[0];
        @(negedge clk);
        req_valid = 1'b0; req_va = ~va;
        cyc = 0;
        while (!rsp_valid && cyc < 100) begin
            if (req_ready) begin
                chk(1'b0, "R1", "ready while busy", 64'(req_ready), 64'd0);
            end
            @(negedge clk);
            cyc++;
        end
        chk(rsp_valid == 1'b1, "R1", "response arrives", 64'(rsp_valid), 64'd1);
        chk({rsp_fault, rsp_pa} == {e_fault, e_pa}, rq, "fault/pa",
            64'({rsp_fault, rsp_pa}), 64'({e_fault, e_pa}));
        chk({rsp_ap, rsp_domain, rsp_size} == {e_ap, e_dom, e_sz}, rq, "ap/domain/size",
            64'({rsp_ap, rsp_domain, rsp_size}), 64'({e_ap, e_dom, e_sz}));
        chk({rsp_tex, rsp_c, rsp_b} == {e_tex, e_c, e_b},
            e_fault ? "R12" : rq, "tex/c/b",
            64'({rsp_tex, rsp_c, rsp_b}), 64'({e_tex, e_c, e_b}));
        chk({rsp_xn, rsp_shared} == {1'b0, e_sh}, "R11", "xn/shared",
            64'({rsp_xn, rsp_shared}), 64'({1'b0, e_sh}));
        chk(n_reads - r0 == e_reads, "R4", "read count", 64'(n_reads - r0), 64'(e_reads));
        chk(n_bad_addr == ba0, "R2", "descriptor address misses", 64'(n_bad_addr - ba0), 64'd0);
        chk(n_bad_ns == bn0, "R3", "security tag mismatches", 64'(n_bad_ns - bn0), 64'd0);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R12", "response pulse width", 64'(rsp_valid), 64'd0);
        m_slow = 0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b0 || req_ready == 1'b1, "R1", "ready known in reset", 64'(req_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk({req_ready, rsp_valid, mem_req} == 3'b100, "R1", "reset state",
            64'({req_ready, rsp_valid, mem_req}), 64'h4);
        for (int nsv = 0; nsv < 2; nsv++)
            for (int kind = 0; kind < 8; kind++)
                for (int sel = 0; sel < 4; sel++)
                    walk(kind, sel, nsv);
        ttb_base = 32'hFFFF_C123;
        for (int kind = 2; kind < 8; kind++) walk(kind, kind % 4, kind % 2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule